// File: doc/BRIEF.md
# Firmware Address Remap Window

This block sits between a host-side firmware bus decoder and a local memory bus. Every firmware-space request that the host side accepts is tested against one power-of-two window. A request inside the window is forwarded with a translated local address. A request outside it, or one that arrives while the window is switched off, is dropped, and the block flags the drop with a one-cycle miss pulse.

Translation works on 64 KiB pages. Two 16-bit masks choose the source of each upper address bit. A bit set in the replace mask takes its value from the programmed local base. A bit set in the keep mask takes its value from the request. The low 16 address bits always pass through unchanged.

Software sets up the window through four 32-bit registers. The same register file holds a mode bit and a small set of sticky event flags. Hardware sets an event flag, and software clears it by writing 1 to it.

Top module: `fwrw_top`

## Requirements
- R1: After reset all four registers read as zero, `fwd_valid`, `miss` and `alt_mode` are low, and every status flag is clear.
- R2: The registers sit at byte offsets 0x80 (enable), 0x84 (mode/status), 0x88 (base pair) and 0x8C (mask pair). The enable, base and mask registers read back the full word last written. Any other offset reads as zero.
- R3: A request is forwarded only if enable bits 8 and 10 are both set. If either bit is clear, the request raises `miss` instead.
- R4: A request hits when (req[31:16] AND replace) equals (host base AND replace). The replace mask is mask bits [31:16]. The host base is base-pair bits [15:0].
- R5: On a hit, `fwd_addr[31:16]` = (req[31:16] AND keep) OR (local base AND replace), and `fwd_addr[15:0]` = req[15:0]. The keep mask is mask bits [15:0]. The local base is base-pair bits [31:16].
- R6: A request that misses raises `miss` for exactly one cycle, does not assert `fwd_valid`, and leaves `fwd_addr` at zero.
- R7: `fwd_valid`, `fwd_addr` and `miss` appear on the clock edge that accepts `req_valid`. They are judged with the register values held before that edge, so a register write in the same cycle does not affect that request.
- R8: Bit 17 of the mode/status register is read/write and drives `alt_mode`.
- R9: A high bit of `evt_in` sets status flag i (register bit i, i < NUM_EVT). The flag holds until software writes 1 to that bit at offset 0x84. Writing 0 leaves it unchanged.
- R10: If an event and a write-1 clear hit the same flag in the same cycle, the flag is set afterwards.
- R11: In a cycle after which no request was accepted, `fwd_valid` and `miss` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | RA_W | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | RA_W | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| evt_in | input | NUM_EVT | Hardware event set pulses for status flags |
| req_valid | input | 1 | Host firmware request accepted this cycle |
| req_addr | input | 32 | Host firmware address of the request |
| fwd_valid | output | 1 | Forwarded request to the local bus |
| fwd_addr | output | 32 | Translated local address |
| miss | output | 1 | One-cycle pulse for a dropped request |
| alt_mode | output | 1 | Alternate firmware-to-local-bus mode select |

## Verification
Several properties are checked by the assertions on every cycle. `fwd_valid` and `miss` never assert together. No result appears without a request. A forward always keeps the low 16 request bits and needs both enable bits to have been set. Status flags never drop unless a write-1 clear was issued, and an event always leaves its flag set. The bench scenarios are the only way to show the full address substitution for chosen window sizes and the hit/miss boundary at the window edges. They also show that a register write does not affect a request accepted in the same cycle, and they cover the readback layout of each register.

// File: rtl/fwrw_pkg.sv
package fwrw_pkg;

  localparam int OFF_EN   = 'h80;
  localparam int OFF_MODE = 'h84;
  localparam int OFF_BASE = 'h88;
  localparam int OFF_MASK = 'h8C;

  localparam int EN_BIT_A  = 8;
  localparam int EN_BIT_B  = 10;
  localparam int MODE_BIT  = 17;
  localparam int PAGE_BITS = 16;

  // window match on the upper half, only bits selected by the replace mask
  function automatic logic win_hit(input logic [15:0] req_hi,
                                   input logic [15:0] host_base,
                                   input logic [15:0] repl);
    return ((req_hi ^ host_base) & repl) == 16'h0000;
  endfunction

  // translated local address: kept request bits merged with local base bits
  function automatic logic [31:0] win_xlate(input logic [31:0] req,
                                            input logic [15:0] loc_base,
                                            input logic [15:0] repl,
                                            input logic [15:0] keep);
    logic [15:0] hi;
    hi = (req[31:16] & keep) | (loc_base & repl);
    return {hi, req[15:0]};
  endfunction

endpackage

// File: rtl/fwrw_stat_bit.sv
module fwrw_stat_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/fwrw_regs.sv
module fwrw_regs
  import fwrw_pkg::*;
#(
  parameter int RA_W    = 8,
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RA_W-1:0]    wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [RA_W-1:0]    rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [31:0]        en_q,
  output logic [31:0]        base_q,
  output logic [31:0]        mask_q,
  output logic               mode_q,
  output logic [NUM_EVT-1:0] status_q
);
  localparam logic [RA_W-1:0] A_EN   = RA_W'(OFF_EN);
  localparam logic [RA_W-1:0] A_MODE = RA_W'(OFF_MODE);
  localparam logic [RA_W-1:0] A_BASE = RA_W'(OFF_BASE);
  localparam logic [RA_W-1:0] A_MASK = RA_W'(OFF_MASK);

  logic wr_en_sel, wr_mode_sel, wr_base_sel, wr_mask_sel;
  logic [NUM_EVT-1:0] clr_vec;

  assign wr_en_sel   = wr_en && (wr_addr == A_EN);
  assign wr_mode_sel = wr_en && (wr_addr == A_MODE);
  assign wr_base_sel = wr_en && (wr_addr == A_BASE);
  assign wr_mask_sel = wr_en && (wr_addr == A_MASK);
  assign clr_vec     = wr_mode_sel ? wr_data[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      base_q <= '0;
      mask_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (wr_en_sel)   en_q   <= wr_data;
      if (wr_base_sel) base_q <= wr_data;
      if (wr_mask_sel) mask_q <= wr_data;
      if (wr_mode_sel) mode_q <= wr_data[MODE_BIT];
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
    fwrw_stat_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_in[i]),
      .clr_i (clr_vec[i]),
      .q_o   (status_q[i])
    );
  end

  logic [31:0] mode_word;
  always_comb begin
    mode_word = '0;
    mode_word[MODE_BIT] = mode_q;
    mode_word[NUM_EVT-1:0] = status_q;
  end

  always_comb begin
    unique case (rd_addr)
      A_EN:    rd_data = en_q;
      A_MODE:  rd_data = mode_word;
      A_BASE:  rd_data = base_q;
      A_MASK:  rd_data = mask_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fwrw_xlate.sv
module fwrw_xlate
  import fwrw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        fw_on,
  input  logic [31:0] base_q,
  input  logic [31:0] mask_q,
  output logic        fwd_valid,
  output logic [31:0] fwd_addr,
  output logic        miss
);
  logic [15:0] repl_m, keep_m, host_b, loc_b;
  logic        hit_w, take_w, drop_w;
  logic [31:0] xl_w;

  assign repl_m = mask_q[31:16];
  assign keep_m = mask_q[15:0];
  assign loc_b  = base_q[31:16];
  assign host_b = base_q[15:0];

  assign hit_w  = win_hit(req_addr[31:16], host_b, repl_m);
  assign take_w = req_valid && fw_on && hit_w;
  assign drop_w = req_valid && !take_w;
  assign xl_w   = win_xlate(req_addr, loc_b, repl_m, keep_m);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_addr  <= '0;
      miss      <= 1'b0;
    end else begin
      fwd_valid <= take_w;
      fwd_addr  <= take_w ? xl_w : '0;
      miss      <= drop_w;
    end
  end
endmodule

// File: rtl/fwrw_top.sv
module fwrw_top
  import fwrw_pkg::*;
#(
  parameter int RA_W    = 8,
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RA_W-1:0]    wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [RA_W-1:0]    rd_addr,
  output logic [31:0]        rd_data,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               req_valid,
  input  logic [31:0]        req_addr,
  output logic               fwd_valid,
  output logic [31:0]        fwd_addr,
  output logic               miss,
  output logic               alt_mode
);
  initial begin
    if (NUM_EVT < 1 || NUM_EVT > 16)
      $error("NUM_EVT must be 1..16 to stay clear of the mode bit");
    if (RA_W < 8) $error("RA_W must reach offset 0x8C");
  end

  logic [31:0]        en_q, base_q, mask_q;
  logic               mode_q;
  logic [NUM_EVT-1:0] status_q;
  logic               fw_on;

  fwrw_regs #(.RA_W(RA_W), .NUM_EVT(NUM_EVT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .evt_in   (evt_in),
    .en_q     (en_q),
    .base_q   (base_q),
    .mask_q   (mask_q),
    .mode_q   (mode_q),
    .status_q (status_q)
  );

  assign fw_on    = en_q[EN_BIT_A] & en_q[EN_BIT_B];
  assign alt_mode = mode_q;

  fwrw_xlate u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .fw_on     (fw_on),
    .base_q    (base_q),
    .mask_q    (mask_q),
    .fwd_valid (fwd_valid),
    .fwd_addr  (fwd_addr),
    .miss      (miss)
  );
endmodule

// File: rtl/fwrw_chk.sv
module fwrw_chk
  import fwrw_pkg::*;
#(
  parameter int RA_W    = 8,
  parameter int NUM_EVT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [RA_W-1:0]    wr_addr,
  input logic [31:0]        wr_data,
  input logic [NUM_EVT-1:0] evt_in,
  input logic               req_valid,
  input logic [31:0]        req_addr,
  input logic [31:0]        en_q,
  input logic [NUM_EVT-1:0] status_q,
  input logic               fwd_valid,
  input logic [31:0]        fwd_addr,
  input logic               miss
);
  logic [NUM_EVT-1:0] clr_w;
  assign clr_w = (wr_en && wr_addr == RA_W'(OFF_MODE)) ? wr_data[NUM_EVT-1:0] : '0;

  AST_FWD_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && miss)); // R6

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> (!fwd_valid && !miss)); // R11

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_addr[15:0] == $past(req_addr[15:0]))); // R5

  AST_FWD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(en_q[EN_BIT_A] && en_q[EN_BIT_B])); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & $past(status_q & ~clr_w)) == $past(status_q & ~clr_w))); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & $past(evt_in)) == $past(evt_in))); // R10
endmodule

bind fwrw_top fwrw_chk #(.RA_W(RA_W), .NUM_EVT(NUM_EVT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .evt_in    (evt_in),
  .req_valid (req_valid),
  .req_addr  (req_addr),
  .en_q      (en_q),
  .status_q  (status_q),
  .fwd_valid (fwd_valid),
  .fwd_addr  (fwd_addr),
  .miss      (miss)
);

// File: tb/sim_fwrw_top.sv
`timescale 1ns/1ps
module sim_fwrw_top;
  localparam int RA_W = 8;
  localparam int NE   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [RA_W-1:0] wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [RA_W-1:0] rd_addr = '0;
  logic [31:0]     rd_data;
  logic [NE-1:0]   evt_in = '0;
  logic            req_valid = 1'b0;
  logic [31:0]     req_addr = '0;
  logic            fwd_valid, miss, alt_mode;
  logic [31:0]     fwd_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fwrw_top #(.RA_W(RA_W), .NUM_EVT(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .req_valid(req_valid),
    .req_addr(req_addr), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .miss(miss),
    .alt_mode(alt_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = RA_W'(off); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int off, output logic [31:0] d);
    rd_addr = RA_W'(off);
    #0.5;
    d = rd_data;
  endtask

  // one request; sampled at the negedge after the accepting edge
  task automatic req(input logic [31:0] a, output logic fv, output logic [31:0] fa,
                     output logic ms);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    fv = fwd_valid; fa = fwd_addr; ms = miss;
  endtask

  // expected translation written bit by bit
  function automatic logic [31:0] model(input logic [31:0] a, input logic [15:0] lb,
                                         input logic [15:0] rp, input logic [15:0] kp);
    logic [31:0] r;
    r = a;
    for (int i = 0; i < 16; i++) begin
      r[16+i] = (rp[i] && lb[i]) || (kp[i] && a[16+i]);
    end
    return r;
  endfunction

  task automatic set_window(input logic [31:0] size, input logic [31:0] host_off,
                            input logic [31:0] loc_base);
    logic [31:0] m;
    m = {16'(~(size - 1) >> 16), 16'((size >> 16) - 1)};
    wr('h88, {loc_base[31:16], host_off[31:16]});
    wr('h8C, m);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd('h80, d); chk("R1 en reset", d, 0);
    rd('h84, d); chk("R1 mode reset", d, 0);
    rd('h88, d); chk("R1 base reset", d, 0);
    rd('h8C, d); chk("R1 mask reset", d, 0);
    chk("R1 outputs reset", {29'b0, fwd_valid, miss, alt_mode}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr('h88, 32'hA5A5_5A5A); rd('h88, d); chk("R2 base rb", d, 32'hA5A5_5A5A);
    wr('h8C, 32'h1234_8765); rd('h8C, d); chk("R2 mask rb", d, 32'h1234_8765);
    wr('h80, 32'hDEAD_BEEF); rd('h80, d); chk("R2 en rb", d, 32'hDEAD_BEEF);
    rd('h90, d); chk("R2 unmapped", d, 0);
    wr('h80, 0);
  endtask

  task automatic t_enable();
    logic fv, ms; logic [31:0] fa;
    set_window(32'h0010_0000, 32'h0E00_0000, 32'h9800_0000);
    req(32'h0E05_1234, fv, fa, ms); chk("R3 disabled miss", {fv, ms}, 2'b01);
    wr('h80, 32'h0000_0100);
    req(32'h0E05_1234, fv, fa, ms); chk("R3 one bit only", {fv, ms}, 2'b01);
    wr('h80, 32'h0000_0400);
    req(32'h0E05_1234, fv, fa, ms); chk("R3 other bit only", {fv, ms}, 2'b01);
    wr('h80, 32'h0000_0500);
    req(32'h0E05_1234, fv, fa, ms); chk("R3 both bits hit", {fv, ms}, 2'b10);
  endtask

  task automatic t_xlate();
    logic fv, ms; logic [31:0] fa;
    set_window(32'h0010_0000, 32'h0E00_0000, 32'h9800_0000);
    req(32'h0E05_1234, fv, fa, ms);
    chk("R5 xlate 1M", fa, model(32'h0E05_1234, 16'h9800, 16'hFFF0, 16'h000F));
    req(32'h0E0F_FFFF, fv, fa, ms); chk("R4 top edge hit", {fv, ms}, 2'b10);
    chk("R5 top edge addr", fa, 32'h980F_FFFF);
    req(32'h0E10_0000, fv, fa, ms); chk("R4 past edge miss", {fv, ms}, 2'b01);
    chk("R6 miss addr zero", fa, 0);
    req(32'h0DFF_FFFF, fv, fa, ms); chk("R4 below edge miss", {fv, ms}, 2'b01);
    set_window(32'h0400_0000, 32'h0400_0000, 32'hC000_0000);
    req(32'h07AB_CDEF, fv, fa, ms); chk("R4 64M hit", {fv, ms}, 2'b10);
    chk("R5 xlate 64M", fa, model(32'h07AB_CDEF, 16'hC000, 16'hFC00, 16'h03FF));
    set_window(32'h0001_0000, 32'h0003_0000, 32'h1234_0000);
    req(32'h0003_BEEF, fv, fa, ms); chk("R5 xlate 64K", fa, 32'h1234_BEEF);
  endtask

  task automatic t_pulse();
    @(negedge clk);
    chk("R11 idle no outputs", {30'b0, fwd_valid, miss}, 0);
    req_valid = 1'b1; req_addr = 32'hFFFF_0000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 miss high", {31'b0, miss}, 1);
    @(negedge clk);
    chk("R6 miss one cycle", {31'b0, miss}, 0);
  endtask

  task automatic t_same_cycle();
    logic fv, ms; logic [31:0] fa;
    set_window(32'h0010_0000, 32'h0E00_0000, 32'h9800_0000);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h80; wr_data = 0;
    req_valid = 1'b1; req_addr = 32'h0E00_0042;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R7 old regs used", {30'b0, fwd_valid, miss}, 2);
    chk("R7 old regs addr", fwd_addr, 32'h9800_0042);
    req(32'h0E00_0042, fv, fa, ms); chk("R7 new regs next", {fv, ms}, 2'b01);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr('h84, 32'h0002_0000);
    rd('h84, d); chk("R8 mode set rb", d, 32'h0002_0000);
    chk("R8 alt_mode high", {31'b0, alt_mode}, 1);
    wr('h84, 0);
    chk("R8 alt_mode low", {31'b0, alt_mode}, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); evt_in = 4'b0101;
    @(negedge clk); evt_in = 0;
    rd('h84, d); chk("R9 flags set", d, 32'h5);
    wr('h84, 0); rd('h84, d); chk("R9 zero write no effect", d, 32'h5);
    wr('h84, 32'h1); rd('h84, d); chk("R9 w1c clears one", d, 32'h4);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h84; wr_data = 32'h4; evt_in = 4'b0100;
    @(negedge clk);
    wr_en = 1'b0; evt_in = 0;
    rd('h84, d); chk("R10 set wins", d, 32'h4);
    wr('h84, 32'hF); rd('h84, d); chk("R9 all cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_enable();
    t_xlate();
    t_pulse();
    t_same_cycle();
    t_mode();
    t_status();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule